// File: doc/BRIEF.md
# Reloadable Millisecond Interval Timer

This block is a free-running periodic timer that raises a level interrupt once per programmed interval. A prescaler divides the core clock down to a one-millisecond tick, and a period counter counts those ticks against a reload value. The interval is therefore (reload + 1) milliseconds, so the interrupt rate in hertz is 1000 / (reload + 1).

Software programs the interval by writing the reload register. That write drops any pending interrupt and restarts both the prescaler and the period counter, so the first interrupt after it comes one full new interval later. Software acknowledges an interrupt with a read strobe on the count register. When a period ends, the counter reloads by itself, so the timer keeps running whether or not the interrupt has been acknowledged.

Top module: `ms_interval_timer`

## Requirements
- R1: Reset forces `timer_irq` low and the reload value to 0. The first interrupt after reset is released comes at the CYC_PER_MS-th rising clock edge.
- R2: The interval is counted in whole milliseconds of CYC_PER_MS clock cycles each. With reload 0, consecutive interrupts are exactly CYC_PER_MS edges apart.
- R3: After the reload register is written with value V, `timer_irq` goes high at the rising edge CYC_PER_MS*(V+1) after the write edge, and not before.
- R4: `timer_irq` is a level. Once high, it stays high until it is acknowledged or the reload register is written.
- R5: A `count_rd` strobe clears `timer_irq` at the next edge. If a period expires in that same cycle, the new interrupt wins and `timer_irq` stays high.
- R6: A `reload_wr` strobe clears `timer_irq` at its edge, loads `reload_val`, and restarts timing from zero, also in the middle of a period.
- R7: The timer is free-running. After each expiry the next one follows (V+1) ms later without any software action, and an acknowledgement does not shift that schedule.
- R8: A reload write in the same cycle as an expiry suppresses that interrupt. The new interval counts from the write edge.
- R9: The reload value is RLD_W bits wide. The largest value, 511 at the default width, gives a 512 ms interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_wr | input | 1 | Write strobe for the reload register; also restarts timing |
| reload_val | input | RLD_W | Reload value written with `reload_wr` |
| count_rd | input | 1 | Read strobe on the count register; acknowledges the interrupt |
| timer_irq | output | 1 | Level interrupt, high once a period has expired |

## Verification
The bench counts clock edges from each reload write to the rising interrupt. A prescaler or period comparator that is off by one shows up as an interval one millisecond or one cycle too long or too short, including at the largest reload value. It issues a second write partway through a period and another on the exact expiry edge. A design that does not restart, or that lets the old expiry through, raises the interrupt early or at that edge. It also acknowledges on the expiry edge and right after an interrupt. A design that gives the acknowledgement priority loses an interrupt, and one that restarts on acknowledgement delays the next interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Event applied to the interrupt latch in one cycle, already resolved
    // by priority: restart beats expiry, expiry beats acknowledge.
    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_ACK     = 2'd1,
        EV_EXPIRE  = 2'd2,
        EV_RESTART = 2'd3
    } irq_ev_e;

    localparam int DEF_RLD_W = 9;

endpackage

// File: rtl/tmr_ms_prescaler.sv
module tmr_ms_prescaler #(
    parameter int CYC_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick
);

    generate
        if (CYC_PER_MS <= 1) begin : g_direct
            // Every cycle is a millisecond tick.
            assign ms_tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(CYC_PER_MS);
            localparam logic [PW-1:0] LAST = PW'(CYC_PER_MS - 1);

            typedef struct packed {
                logic [PW-1:0] cnt;
            } pre_st_t;

            pre_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (restart) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign ms_tick = (st_q.cnt == LAST);

            // The divider count never passes its terminal value (R2).
            assert_pre_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cnt <= LAST);

            // A restart always leaves the divider at the start of a millisecond (R6).
            assert_pre_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !ms_tick);
        end
    endgenerate

endmodule

// File: rtl/tmr_period_counter.sv
module tmr_period_counter #(
    parameter int RLD_W = tmr_pkg::DEF_RLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             restart,
    input  logic [RLD_W-1:0] rld_in,
    output logic             expire
);

    typedef struct packed {
        logic [RLD_W-1:0] ms;
        logic [RLD_W-1:0] rld;
    } per_st_t;

    per_st_t st_d, st_q;

    // A restart in the same cycle overrides an expiry from the old state.
    assign expire = ms_tick && !restart && (st_q.ms == st_q.rld);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.ms  = '0;
            st_d.rld = rld_in;
        end else if (ms_tick) begin
            if (st_q.ms == st_q.rld) begin
                st_d.ms = '0;
            end else begin
                st_d.ms = st_q.ms + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Expiry happens only on a millisecond tick (R3).
    assert_expire_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> ms_tick);

    // The elapsed-millisecond count never passes the reload value (R3).
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ms <= st_q.rld);

    // The reload value changes only through a write (R6).
    assert_reload_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(st_q.rld));

    // After an expiry the count starts over, so the timer runs free (R7).
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (st_q.ms == '0));

endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ack_rd,
    input  logic restart,
    output logic irq
);

    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t st_d, st_q;
    irq_ev_e ev;

    always_comb begin
        if (restart) begin
            ev = EV_RESTART;
        end else if (expire) begin
            ev = EV_EXPIRE;
        end else if (ack_rd) begin
            ev = EV_ACK;
        end else begin
            ev = EV_NONE;
        end
    end

    always_comb begin
        st_d = st_q;
        case (ev)
            EV_RESTART: st_d.pend = 1'b0;
            EV_EXPIRE:  st_d.pend = 1'b1;
            EV_ACK:     st_d.pend = 1'b0;
            default:    st_d.pend = st_q.pend;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.pend;

    assert_set_on_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !restart) |=> irq);

    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_rd && !restart) |=> irq);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !expire && !restart) |=> !irq);

    assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !irq);

endmodule

// File: rtl/ms_interval_timer.sv
module ms_interval_timer #(
    parameter int CYC_PER_MS = 125000,
    parameter int RLD_W      = tmr_pkg::DEF_RLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_wr,
    input  logic [RLD_W-1:0] reload_val,
    input  logic             count_rd,
    output logic             timer_irq
);

    logic ms_tick;
    logic expire;

    tmr_ms_prescaler #(
        .CYC_PER_MS(CYC_PER_MS)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload_wr),
        .ms_tick (ms_tick)
    );

    tmr_period_counter #(
        .RLD_W(RLD_W)
    ) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .restart (reload_wr),
        .rld_in  (reload_val),
        .expire  (expire)
    );

    tmr_irq_latch u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .ack_rd  (count_rd),
        .restart (reload_wr),
        .irq     (timer_irq)
    );

    // A write in the expiry cycle suppresses that interrupt (R8).
    assert_write_beats_expiry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> !timer_irq);

endmodule

// File: tb/ms_interval_timer_test.sv
module ms_interval_timer_test;

    localparam int N     = 4;
    localparam int RLD_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reload_wr = 1'b0;
    logic [RLD_W-1:0] reload_val = '0;
    logic             count_rd = 1'b0;
    logic             timer_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ms_interval_timer #(.CYC_PER_MS(N), .RLD_W(RLD_W)) uut (
        .clk(clk), .rst_n(rst_n), .reload_wr(reload_wr),
        .reload_val(reload_val), .count_rd(count_rd), .timer_irq(timer_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int v);
        @(negedge clk);
        reload_wr = 1'b1;
        reload_val = RLD_W'(v);
        @(posedge clk);
        #1;
        reload_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        count_rd = 1'b1;
        @(posedge clk);
        #1;
        count_rd = 1'b0;
    endtask

    // Counts rising edges until the interrupt is seen high.
    task automatic edges_to_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!timer_irq && n < 5000);
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq low in reset", timer_irq, 0);
        @(negedge clk);
        rst_n = 1'b1;
        edges_to_irq(n);
        chk("R1 first interval after reset", n, N);
    endtask

    task automatic t_level_and_ack();
        int n;
        repeat (2) @(posedge clk);
        #1;
        chk("R4 irq held", timer_irq, 1);
        do_read();
        chk("R5 read clears irq", timer_irq, 0);
    endtask

    task automatic t_interval(input int v, input string req);
        int n;
        do_write(v);
        chk({req, " irq low after write"}, timer_irq, 0);
        edges_to_irq(n);
        chk({req, " interval"}, n, N * (v + 1));
    endtask

    task automatic t_free_run();
        int n;
        do_write(2);
        edges_to_irq(n);
        chk("R7 first period", n, 12);
        do_read();
        chk("R5 ack after expiry", timer_irq, 0);
        edges_to_irq(n);
        chk("R7 next period unshifted by ack", n, 11);
        do_write(0);
        edges_to_irq(n);
        do_read();
        edges_to_irq(n);
        chk("R2 reload 0 spacing", n, N - 1);
    endtask

    task automatic t_restart_mid();
        int n;
        do_write(1);
        repeat (5) @(posedge clk);
        #1;
        do_write(1);
        edges_to_irq(n);
        chk("R6 restart mid-period", n, 8);
        do_write(1);
        chk("R6 write clears pending irq", timer_irq, 0);
    endtask

    task automatic t_write_at_expiry();
        int n;
        do_write(0);
        repeat (N - 1) @(posedge clk);
        do_write(0);
        chk("R8 write on expiry edge suppresses irq", timer_irq, 0);
        edges_to_irq(n);
        chk("R8 interval counts from write", n, N);
    endtask

    task automatic t_read_at_expiry();
        do_write(0);
        repeat (N - 1) @(posedge clk);
        do_read();
        chk("R5 expiry wins over ack", timer_irq, 1);
    endtask

    initial begin
        t_reset();
        t_level_and_ack();
        t_interval(3, "R3");
        t_interval(6, "R3");
        t_free_run();
        t_restart_mid();
        t_write_at_expiry();
        t_read_at_expiry();
        t_interval(511, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule